// File: doc/BRIEF.md
# Sprite Zero Overlap Flag

This block watches the pixel pipeline of a tile-and-sprite video generator. It raises a sticky status flag the first time in a frame that an opaque pixel from sprite output unit 0 lands on an opaque background pixel. Unit 0 only holds sprite zero when sprite zero is on the current line. A pixel counts as opaque when its 2-bit pattern index is not zero. Colour, palette and sprite-behind-background priority play no part in the decision.

The rendering pipeline feeds the block once per pixel:
- both 2-bit pattern indices;
- the x position of the pixel;
- the two render enables;
- the two left-column show enables.

The sprite evaluator supplies a "sprite zero on next line" bit. The block copies that bit into its own current-line flag at each line boundary, so evaluation of the following line can change its output freely while the current line is being drawn.

The frame timer pulses a clear input at dot 1 of the pre-render line. That pulse drops the flag again, so each frame records only its first overlap. A status read can sample `hit_flag` at any time.

Top module: `spr0_hit_detect`

## Requirements
- R1: The flag rises only after a cycle with `pix_valid` high, the current-line sprite-zero bit set, a sprite index other than 2'b00 and a background index other than 2'b00. Index 2'b00 means transparent.
- R2: Each of the index values 2'b01, 2'b10 and 2'b11 counts as opaque, for the sprite and for the background alike.
- R3: No hit is recorded while `bg_on` or `spr_on` is 0.
- R4: At x from 0 to 7, no hit is recorded when `bg_left_en` or `spr_left_en` is 0. At those positions a hit is recorded when both are 1. From x = 8 upward the left enables have no effect.
- R5: No hit is ever recorded at x = 255.
- R6: The flag reads 1 starting one clock after the qualifying pixel.
- R7: Once set, the flag stays 1 through later pixels and line boundaries until `frame_clr` is high. A `frame_clr` cycle leaves the flag 0 on the next clock, even if a qualifying pixel arrives in the same cycle.
- R8: The current-line sprite-zero bit takes the value of `s0_next` only in cycles where `line_start` is high. Changes to `s0_next` between boundaries do not change which pixels can hit.
- R9: After reset the flag is 0 and the current-line sprite-zero bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_x | input | 8 | X position of the presented pixel |
| bg_idx | input | 2 | Background pattern index, 0 = transparent |
| spr_idx | input | 2 | Sprite unit 0 pattern index, 0 = transparent |
| bg_on | input | 1 | Background rendering enabled |
| spr_on | input | 1 | Sprite rendering enabled |
| bg_left_en | input | 1 | Background shown in the leftmost 8 columns |
| spr_left_en | input | 1 | Sprites shown in the leftmost 8 columns |
| s0_next | input | 1 | Sprite zero found in range for the next line |
| line_start | input | 1 | Line boundary pulse; loads the current-line bit |
| frame_clr | input | 1 | Pre-render dot-1 pulse; clears the flag |
| hit_flag | output | 1 | Sticky sprite-zero overlap flag |

## Verification
The hardest case to reach from the ports is a mismatch between the current-line bit and `s0_next`. It needs a line boundary that loads one value, then a flip of `s0_next` before the pixel arrives.

Every trial of the sweep does exactly that. For each combination of both indices, both enables, both left enables, the sprite-zero bit and the edge x positions 0, 7, 8, 254 and 255, the trial clears the flag, loads the bit and then inverts `s0_next`. Separate sequences cover the sticky hold and a clear that coincides with a hit.

// File: rtl/spr0_hit_detect.sv
module spr0_hit_detect #(
  parameter int XW      = 8,
  parameter int IDXW    = 2,
  parameter int CLIP_W  = 8,
  parameter int LAST_X  = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_valid,
  input  logic [XW-1:0]   pix_x,
  input  logic [IDXW-1:0] bg_idx,
  input  logic [IDXW-1:0] spr_idx,
  input  logic            bg_on,
  input  logic            spr_on,
  input  logic            bg_left_en,
  input  logic            spr_left_en,
  input  logic            s0_next,
  input  logic            line_start,
  input  logic            frame_clr,
  output logic            hit_flag
);
  localparam logic [XW-1:0] CLIP_END = XW'(CLIP_W);
  localparam logic [XW-1:0] EDGE_X   = XW'(LAST_X);

  logic s0_cur;
  logic opaque_both;
  logic render_ok;
  logic in_clip;
  logic x_ok;
  logic hit_now;

  assign opaque_both = (|bg_idx) && (|spr_idx);
  assign render_ok   = bg_on && spr_on;
  assign in_clip     = (pix_x < CLIP_END) && !(bg_left_en && spr_left_en);
  assign x_ok        = !in_clip && (pix_x != EDGE_X);
  assign hit_now     = pix_valid && s0_cur && opaque_both && render_ok && x_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)          s0_cur <= 1'b0;
    else if (line_start) s0_cur <= s0_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         hit_flag <= 1'b0;
    else if (frame_clr) hit_flag <= 1'b0;
    else if (hit_now)   hit_flag <= 1'b1;
  end
endmodule

// File: rtl/spr0_hit_detect_chk.sv
module spr0_hit_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_valid,
  input logic [7:0] pix_x,
  input logic [1:0] bg_idx,
  input logic [1:0] spr_idx,
  input logic       bg_on,
  input logic       spr_on,
  input logic       bg_left_en,
  input logic       spr_left_en,
  input logic       s0_next,
  input logic       line_start,
  input logic       frame_clr,
  input logic       s0_cur,
  input logic       hit_flag
);
  // R1
  rise_needs_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> $past(pix_valid && s0_cur && bg_idx != 2'b00 && spr_idx != 2'b00));
  // R3
  rise_needs_render_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> $past(bg_on && spr_on));
  // R4
  rise_outside_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> $past(pix_x >= 8'd8 || (bg_left_en && spr_left_en)));
  // R5
  no_edge_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> $past(pix_x) != 8'd255);
  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> !hit_flag);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && !frame_clr) |=> hit_flag);
  // R8
  s0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> s0_cur == $past(s0_next));
  // R8
  s0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(s0_cur));
endmodule

bind spr0_hit_detect spr0_hit_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
  .bg_idx(bg_idx), .spr_idx(spr_idx), .bg_on(bg_on), .spr_on(spr_on),
  .bg_left_en(bg_left_en), .spr_left_en(spr_left_en), .s0_next(s0_next),
  .line_start(line_start), .frame_clr(frame_clr), .s0_cur(s0_cur),
  .hit_flag(hit_flag)
);

// File: tb/sim_spr0_hit_detect.sv
`timescale 1ns/1ps
module sim_spr0_hit_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic [7:0] pix_x = '0;
  logic [1:0] bg_idx = '0, spr_idx = '0;
  logic bg_on = 1'b0, spr_on = 1'b0, bg_left_en = 1'b0, spr_left_en = 1'b0;
  logic s0_next = 1'b0, line_start = 1'b0, frame_clr = 1'b0;
  logic hit_flag;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spr0_hit_detect u0 (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
    .bg_idx(bg_idx), .spr_idx(spr_idx), .bg_on(bg_on), .spr_on(spr_on),
    .bg_left_en(bg_left_en), .spr_left_en(spr_left_en), .s0_next(s0_next),
    .line_start(line_start), .frame_clr(frame_clr), .hit_flag(hit_flag)
  );

  task automatic check(input logic exp, input string req);
    total++;
    if (hit_flag !== exp) begin
      bad++;
      $display("FAIL %s: hit_flag=%b expected=%b", req, hit_flag, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_frame();
    frame_clr = 1'b1; tick(); frame_clr = 1'b0;
  endtask

  task automatic load_line(input logic v);
    s0_next = v; line_start = 1'b1; tick(); line_start = 1'b0;
  endtask

  task automatic pixel(input logic [7:0] x, input logic [1:0] b, input logic [1:0] s);
    pix_x = x; bg_idx = b; spr_idx = s; pix_valid = 1'b1; tick(); pix_valid = 1'b0;
  endtask

  initial begin
    int xs[5] = '{0, 7, 8, 254, 255};
    repeat (3) tick();
    check(1'b0, "R9");
    rst_n = 1'b1;
    tick();
    // R9: a pixel right after reset sees the cleared current-line bit
    bg_on = 1; spr_on = 1; bg_left_en = 1; spr_left_en = 1;
    pixel(8'd50, 2'd3, 2'd3);
    check(1'b0, "R9");

    for (int s0 = 0; s0 < 2; s0++)
      for (int en = 0; en < 4; en++)
        for (int le = 0; le < 4; le++)
          for (int xi = 0; xi < 5; xi++)
            for (int b = 0; b < 4; b++)
              for (int s = 0; s < 4; s++) begin
                logic exp;
                string req;
                bg_on = en[0]; spr_on = en[1];
                bg_left_en = le[0]; spr_left_en = le[1];
                clear_frame();
                load_line(s0[0]);
                s0_next = ~s0[0];          // R8: must not matter
                tick();
                check(1'b0, "R7");
                pixel(8'(xs[xi]), 2'(b), 2'(s));
                // R6: sampled one clock after the pixel edge
                exp = 1'b1; req = "R6";
                if (s == 0 || b == 0)                     begin exp = 0; req = "R1"; end
                else if (s0 == 0)                         begin exp = 0; req = "R8"; end
                else if (en != 3)                         begin exp = 0; req = "R3"; end
                else if (xs[xi] < 8 && le != 3)           begin exp = 0; req = "R4"; end
                else if (xs[xi] == 255)                   begin exp = 0; req = "R5"; end
                else if (b != 3 || s != 3)                req = "R2";
                check(exp, req);
              end

    // R7: sticky across non-qualifying pixels and line boundaries
    bg_on = 1; spr_on = 1; bg_left_en = 1; spr_left_en = 1;
    clear_frame();
    load_line(1'b1);
    pixel(8'd40, 2'd1, 2'd2);
    check(1'b1, "R6");
    pixel(8'd41, 2'd0, 2'd0);
    load_line(1'b0);
    pixel(8'd42, 2'd0, 2'd1);
    tick();
    check(1'b1, "R7");
    clear_frame();
    check(1'b0, "R7");
    // R7: clear in the same cycle as a qualifying pixel
    load_line(1'b1);
    pix_x = 8'd60; bg_idx = 2'd2; spr_idx = 2'd2; pix_valid = 1'b1; frame_clr = 1'b1;
    tick();
    pix_valid = 1'b0; frame_clr = 1'b0;
    check(1'b0, "R7");
    // R8: bit picked up only at the boundary
    load_line(1'b0);
    s0_next = 1'b1;
    pixel(8'd70, 2'd3, 2'd3);
    check(1'b0, "R8");
    load_line(1'b1);
    pixel(8'd70, 2'd3, 2'd3);
    check(1'b1, "R8");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule